// File: doc/BRIEF.md
# Cell Bus Transmit Port (PHY side, 8/16-bit)

This block is one PHY-side port on a shared, multi-port cell transmit bus of the UTOPIA Level 2 kind. The ATM-layer master polls ports by putting an address on the bus. When the address matches this port's configured address, the port answers on the next cycle with a cell-available flag. The flag is set only if a complete 53-byte cell still fits in the internal buffer.

A poll never selects the port. The port is selected only when the enable line goes low and this port's address was on the bus in the cycle before. While the port is selected and enable is low, it takes one bus word per cycle. If enable goes high in the middle of a cell, the transfer pauses. It resumes only after a fresh reselect.

The bus width is set by a mode input. A narrow cell is 53 byte-words. A wide cell is 27 sixteen-bit words, and the wide cell carries one filler byte, which the port drops. Every accepted word is checked for odd parity. A start-of-cell marker that comes early or is missing is reported, and a cell damaged this way is not forwarded. Complete cells leave through a simple byte-wide valid/ready output, in arrival order.

Top module: `cellbus_tx_port`

## Requirements
- R1: Cell-available is driven one cycle after `tx_addr` equals `cfg_addr`. It is 1 only when at least one whole cell slot is free. Stored cells and a cell currently being received (one that is not being dropped) both count as occupied. For any other address the flag is 0.
- R2: The port is selected only on a high-to-low transition of `tx_enb_n`, and only if `tx_addr` equalled `cfg_addr` in the previous cycle. Polling alone never selects the port. Presenting the address while enable is already low does not select the port either.
- R3: While `tx_enb_n` is high, no word is taken. After a pause, words are taken again only after a reselect as in R2. Words sent with enable low but without a reselect are ignored and do not disturb the cell in progress.
- R4: A word with `tx_soc`=1 that arrives while a cell is incomplete raises `err_soc_early` for exactly one cycle, in the cycle after the word. The partial cell is discarded, and this word starts a new cell.
- R5: A word with `tx_soc`=0 that is taken while no cell is open raises `err_soc_missing` for one cycle, in the cycle after the word. The word is dropped.
- R6: Narrow mode (`cfg_wide`=0): a cell is 53 words. Only `tx_data[7:0]` is stored, and bits [15:8] are ignored. Parity is odd over `tx_data[7:0]` together with `tx_prty`.
- R7: Wide mode (`cfg_wide`=1): a cell is 27 words, and the earlier byte of each word is on `tx_data[15:8]`. The low byte of the third word (byte index 5 of the 54-byte stream) is discarded, so 53 bytes are stored. Parity is odd over all 16 data bits together with `tx_prty`.
- R8: A parity mismatch on any taken word sets `par_err`. The flag stays set until `clr_par_err` is high. A new mismatch in the same cycle as the clear wins. A parity error alone does not discard the cell.
- R9: Stored cells leave in arrival order, one byte per cycle in which `cell_valid` and `cell_ready` are both high. `cell_sof` marks byte 0 and `cell_eof` marks byte 52. While `cell_ready` is low, the byte and the flags hold.
- R10: A cell whose first word arrives while every slot holds a stored cell is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | ADDR_W | This port's bus address |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| clr_par_err | input | 1 | Clears the sticky parity flag |
| tx_addr | input | ADDR_W | Poll/select address from the master |
| tx_enb_n | input | 1 | Transfer enable, active low |
| tx_soc | input | 1 | Start-of-cell marker for the current word |
| tx_data | input | 16 | Bus data word |
| tx_prty | input | 1 | Odd parity bit for the data word |
| tx_clav | output | 1 | Cell-available answer to a poll |
| cell_valid | output | 1 | Output byte valid |
| cell_ready | input | 1 | Output byte accepted |
| cell_byte | output | 8 | Output cell byte |
| cell_sof | output | 1 | First byte of a cell |
| cell_eof | output | 1 | Last byte of a cell |
| err_soc_early | output | 1 | Pulse: start-of-cell inside an open cell |
| err_soc_missing | output | 1 | Pulse: word without start-of-cell outside a cell |
| par_err | output | 1 | Sticky parity error flag |

## Verification
Some properties are checked by assertions on every cycle. Cell-available is only raised after this port's address and when a slot is free. A falling enable without the port's address in the previous cycle never starts word intake, and no word is taken while enable is high. An early start-of-cell is always followed by its error pulse. The parity flag never drops without a clear. The output holds while stalled, and the occupancy never exceeds the slot count. Other behaviours can only be shown by the bench scenarios, because they depend on byte content: that the wide filler byte is removed at the right position, that the upper byte is ignored in narrow mode, that a cell survives a pause and a rejected stray word intact, that a cell broken by framing disappears while the following one arrives whole, and that a cell sent into a full buffer is lost.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
  localparam int CELL_BYTES = 53;
  localparam logic [7:0] NARROW_WORDS = 8'd53;

  // words making up one cell on the bus
  function automatic logic [5:0] words_per_cell(input logic wide);
    return wide ? 6'd27 : 6'd53;
  endfunction

  // odd parity: data bits in use plus parity bit must hold an odd count of ones
  function automatic logic parity_ok(input logic [15:0] d, input logic p, input logic wide);
    return wide ? ^{d, p} : ^{d[7:0], p};
  endfunction

  // stored position of the byte carried in the upper lane (or the only lane when narrow)
  function automatic logic [5:0] lane0_pos(input logic [5:0] w, input logic wide);
    logic [5:0] dbl;
    dbl = {w[4:0], 1'b0};
    if (!wide) return w;
    return (w < 6'd3) ? dbl : dbl - 6'd1;
  endfunction

  // the lower lane carries a stored byte except for the filler in word 2
  function automatic logic lane1_keep(input logic [5:0] w, input logic wide);
    return wide && (w != 6'd2);
  endfunction

  function automatic logic [5:0] lane1_pos(input logic [5:0] w);
    return (w < 6'd2) ? {w[4:0], 1'b1} : {w[4:0], 1'b0};
  endfunction
endpackage

// File: rtl/cellbus_sel.sv
module cellbus_sel #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_enb_n,
  input  logic              space_ok,
  output logic              addr_hit,
  output logic              take_en,
  output logic              clav
);
  logic hit_q;
  logic enb_n_q;
  logic sel_q;
  logic clav_q;

  assign addr_hit = (bus_addr == cfg_addr);
  // a falling enable looks at last cycle's address; a held-low enable keeps the prior choice
  assign take_en  = !bus_enb_n && (enb_n_q ? hit_q : sel_q);
  assign clav     = clav_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      enb_n_q <= 1'b1;
      sel_q   <= 1'b0;
      clav_q  <= 1'b0;
    end else begin
      hit_q   <= addr_hit;
      enb_n_q <= bus_enb_n;
      if (!bus_enb_n) sel_q <= take_en;
      clav_q  <= addr_hit && space_ok;
    end
  end

  AST_CLAV_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    clav |-> $past(addr_hit)); // R1
  AST_SEL_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_enb_n) && !$past(addr_hit)) |-> !take_en); // R2
  AST_PAUSE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_enb_n |-> !take_en); // R3
endmodule

// File: rtl/cellbus_frame.sv
module cellbus_frame
  import cellbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_en,
  input  logic        wide,
  input  logic        soc,
  input  logic [15:0] data,
  input  logic        prty,
  input  logic        clr_par,
  input  logic        slot_free,
  output logic        wr0_en,
  output logic [5:0]  wr0_pos,
  output logic [7:0]  wr0_byte,
  output logic        wr1_en,
  output logic [5:0]  wr1_pos,
  output logic [7:0]  wr1_byte,
  output logic        commit,
  output logic        in_cell,
  output logic        dropping,
  output logic        err_early,
  output logic        err_missing,
  output logic        par_err
);
  logic       in_cell_q;
  logic       drop_q;
  logic [5:0] word_q;
  logic       early_q;
  logic       missing_q;
  logic       par_q;

  logic       start_ev;
  logic       early_ev;
  logic       missing_ev;
  logic       body_ev;
  logic       last_ev;
  logic       bad_par_ev;
  logic [5:0] cur_word;
  logic       cur_drop;

  assign start_ev   = take_en && soc;
  assign early_ev   = start_ev && in_cell_q;
  assign missing_ev = take_en && !soc && !in_cell_q;
  assign body_ev    = take_en && (soc || in_cell_q);
  assign cur_word   = start_ev ? 6'd0 : word_q;
  assign cur_drop   = start_ev ? !slot_free : drop_q;
  assign last_ev    = body_ev && (cur_word == words_per_cell(wide) - 6'd1);
  assign bad_par_ev = take_en && !parity_ok(data, prty, wide);

  assign wr0_en   = body_ev && !cur_drop;
  assign wr0_pos  = lane0_pos(cur_word, wide);
  assign wr0_byte = wide ? data[15:8] : data[7:0];
  assign wr1_en   = body_ev && !cur_drop && lane1_keep(cur_word, wide);
  assign wr1_pos  = lane1_pos(cur_word);
  assign wr1_byte = data[7:0];
  assign commit   = last_ev && !cur_drop;

  assign in_cell     = in_cell_q;
  assign dropping    = drop_q;
  assign err_early   = early_q;
  assign err_missing = missing_q;
  assign par_err     = par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cell_q <= 1'b0;
      drop_q    <= 1'b0;
      word_q    <= 6'd0;
      early_q   <= 1'b0;
      missing_q <= 1'b0;
      par_q     <= 1'b0;
    end else begin
      if (body_ev) begin
        drop_q <= cur_drop;
        if (last_ev) begin
          in_cell_q <= 1'b0;
          word_q    <= 6'd0;
        end else begin
          in_cell_q <= 1'b1;
          word_q    <= cur_word + 6'd1;
        end
      end
      early_q   <= early_ev;
      missing_q <= missing_ev;
      par_q     <= bad_par_ev || (par_q && !clr_par);
    end
  end

  AST_SOC_EARLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && soc && in_cell_q) |=> err_early); // R4
  AST_SOC_MISSING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && !soc && !in_cell_q) |=> (err_missing && !in_cell)); // R5
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !clr_par) |=> par_err); // R8
endmodule

// File: rtl/cellbus_store.sv
module cellbus_store
  import cellbus_pkg::*;
#(
  parameter int CELLS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr0_en,
  input  logic [5:0]                     wr0_pos,
  input  logic [7:0]                     wr0_byte,
  input  logic                           wr1_en,
  input  logic [5:0]                     wr1_pos,
  input  logic [7:0]                     wr1_byte,
  input  logic                           commit,
  input  logic                           out_ready,
  output logic                           out_valid,
  output logic [7:0]                     out_byte,
  output logic                           out_sof,
  output logic                           out_eof,
  output logic                           slot_free,
  output logic [$clog2(CELLS+1)-1:0]     used
);
  localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int CNT_W  = $clog2(CELLS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELLS - 1);
  localparam logic [5:0]        LAST_BYTE = 6'(CELL_BYTES - 1);

  logic [7:0]        mem [0:CELLS-1][0:CELL_BYTES-1];
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;
  logic [5:0]        rd_pos;
  logic [CNT_W-1:0]  used_q;
  logic              pop;
  logic              pop_last;

  assign out_valid = (used_q != '0);
  assign out_byte  = mem[rd_slot][rd_pos];
  assign out_sof   = (rd_pos == 6'd0);
  assign out_eof   = (rd_pos == LAST_BYTE);
  assign pop       = out_valid && out_ready;
  assign pop_last  = pop && out_eof;
  assign slot_free = (used_q < CNT_W'(CELLS));
  assign used      = used_q;

  always_ff @(posedge clk) begin
    if (wr0_en) mem[wr_slot][wr0_pos] <= wr0_byte;
    if (wr1_en) mem[wr_slot][wr1_pos] <= wr1_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= '0;
      rd_slot <= '0;
      rd_pos  <= 6'd0;
      used_q  <= '0;
    end else begin
      if (commit) wr_slot <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
      if (pop) begin
        if (pop_last) begin
          rd_pos  <= 6'd0;
          rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
        end else begin
          rd_pos <= rd_pos + 6'd1;
        end
      end
      case ({commit, pop_last})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (used_q != CNT_W'(CELLS))); // R10
  AST_OUT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_sof) && $stable(out_eof))); // R9
endmodule

// File: rtl/cellbus_tx_port.sv
module cellbus_tx_port
  import cellbus_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CELLS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wide,
  input  logic              clr_par_err,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              tx_enb_n,
  input  logic              tx_soc,
  input  logic [15:0]       tx_data,
  input  logic              tx_prty,
  output logic              tx_clav,
  output logic              cell_valid,
  input  logic              cell_ready,
  output logic [7:0]        cell_byte,
  output logic              cell_sof,
  output logic              cell_eof,
  output logic              err_soc_early,
  output logic              err_soc_missing,
  output logic              par_err
);
  localparam int CNT_W = $clog2(CELLS + 1);

  logic             addr_hit;
  logic             take_en;
  logic             space_ok;
  logic             slot_free;
  logic [CNT_W-1:0] used;
  logic             in_cell;
  logic             dropping;
  logic             reserve;
  logic [CNT_W:0]   busy;
  logic             wr0_en, wr1_en, commit;
  logic [5:0]       wr0_pos, wr1_pos;
  logic [7:0]       wr0_byte, wr1_byte;

  // a cell being written (and kept) holds a slot that is not yet counted as used
  assign reserve  = in_cell && !dropping;
  assign busy     = {1'b0, used} + (CNT_W+1)'(reserve);
  assign space_ok = busy < (CNT_W+1)'(CELLS);

  cellbus_sel #(.ADDR_W(ADDR_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .bus_addr  (tx_addr),
    .bus_enb_n (tx_enb_n),
    .space_ok  (space_ok),
    .addr_hit  (addr_hit),
    .take_en   (take_en),
    .clav      (tx_clav)
  );

  cellbus_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_en     (take_en),
    .wide        (cfg_wide),
    .soc         (tx_soc),
    .data        (tx_data),
    .prty        (tx_prty),
    .clr_par     (clr_par_err),
    .slot_free   (slot_free),
    .wr0_en      (wr0_en),
    .wr0_pos     (wr0_pos),
    .wr0_byte    (wr0_byte),
    .wr1_en      (wr1_en),
    .wr1_pos     (wr1_pos),
    .wr1_byte    (wr1_byte),
    .commit      (commit),
    .in_cell     (in_cell),
    .dropping    (dropping),
    .err_early   (err_soc_early),
    .err_missing (err_soc_missing),
    .par_err     (par_err)
  );

  cellbus_store #(.CELLS(CELLS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr0_en    (wr0_en),
    .wr0_pos   (wr0_pos),
    .wr0_byte  (wr0_byte),
    .wr1_en    (wr1_en),
    .wr1_pos   (wr1_pos),
    .wr1_byte  (wr1_byte),
    .commit    (commit),
    .out_ready (cell_ready),
    .out_valid (cell_valid),
    .out_byte  (cell_byte),
    .out_sof   (cell_sof),
    .out_eof   (cell_eof),
    .slot_free (slot_free),
    .used      (used)
  );

  AST_CLAV_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clav |-> ($past(space_ok) && $past(addr_hit))); // R1
endmodule

// File: tb/cellbus_tx_port_tb.sv
module cellbus_tx_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MY_ADDR = 5'd9;
  localparam logic [4:0] OTHER   = 5'd4;
  localparam logic [4:0] IDLE_A  = 5'd31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        clr_par_err = 1'b0;
  logic [4:0]  tx_addr = IDLE_A;
  logic        tx_enb_n = 1'b1;
  logic        tx_soc = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        tx_prty = 1'b0;
  logic        cell_ready = 1'b1;
  logic        tx_clav, cell_valid, cell_sof, cell_eof;
  logic        err_soc_early, err_soc_missing, par_err;
  logic [7:0]  cell_byte;

  int total = 0;
  int bad = 0;
  logic [7:0] cap [0:1023];
  int cap_n = 0;
  int mark_bad = 0;
  int n_early = 0;
  int n_miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cellbus_tx_port #(.ADDR_W(5), .CELLS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(MY_ADDR), .cfg_wide(cfg_wide),
    .clr_par_err(clr_par_err), .tx_addr(tx_addr), .tx_enb_n(tx_enb_n),
    .tx_soc(tx_soc), .tx_data(tx_data), .tx_prty(tx_prty), .tx_clav(tx_clav),
    .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_byte(cell_byte),
    .cell_sof(cell_sof), .cell_eof(cell_eof), .err_soc_early(err_soc_early),
    .err_soc_missing(err_soc_missing), .par_err(par_err)
  );

  // output monitor: samples between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (cell_valid && cell_ready && cap_n < 1024) begin
        if (cell_sof != ((cap_n % 53) == 0) || cell_eof != ((cap_n % 53) == 52)) mark_bad++;
        cap[cap_n] = cell_byte;
        cap_n++;
      end
      if (err_soc_early) n_early++;
      if (err_soc_missing) n_miss++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] a, input logic en_n, input logic s,
                     input logic [15:0] d, input logic p);
    @(posedge clk); #1;
    tx_addr = a; tx_enb_n = en_n; tx_soc = s; tx_data = d; tx_prty = p;
  endtask

  function automatic logic odd_bit(input logic [15:0] d, input logic wide);
    return wide ? ~^d : ~^d[7:0];
  endfunction

  // 54-byte wide stream: 5 header bytes, filler, then the rest of the cell
  function automatic logic [7:0] stream_byte(input logic [7:0] base, input int j);
    if (j < 5) return base + 8'(j);
    if (j == 5) return 8'hEE;
    return base + 8'(j - 1);
  endfunction

  task automatic send_cell(input logic wide, input logic [7:0] base, input int n_words,
                           input int bad_par_w, input int pause_at, input bit stray,
                           input bit junk_hi);
    int lim;
    lim = (n_words < 0) ? (wide ? 27 : 53) : n_words;
    cyc(MY_ADDR, 1'b1, 1'b0, 16'h0, 1'b0);
    for (int w = 0; w < lim; w++) begin
      logic [15:0] d;
      logic p;
      if (w == pause_at) begin
        cyc(OTHER, 1'b1, 1'b0, 16'hDEAD, 1'b0);
        cyc(OTHER, 1'b1, 1'b0, 16'hBEEF, 1'b0);
        if (stray) cyc(OTHER, 1'b0, 1'b0, 16'h5A5A, odd_bit(16'h5A5A, wide));
        cyc(MY_ADDR, 1'b1, 1'b0, 16'h0, 1'b0);
      end
      if (wide) d = {stream_byte(base, 2*w), stream_byte(base, 2*w + 1)};
      else      d = {junk_hi ? 8'hC1 : 8'h00, base + 8'(w)};
      p = odd_bit(d, wide);
      if (w == bad_par_w) p = ~p;
      cyc(IDLE_A, 1'b0, (w == 0), d, p);
    end
    cyc(IDLE_A, 1'b1, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic poll(input logic [4:0] a, output logic v);
    cyc(a, 1'b1, 1'b0, 16'h0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    v = tx_clav;
  endtask

  task automatic settle();
    repeat (70) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cell_matches(input int at, input logic [7:0] base, input string req);
    int miss = 0;
    for (int i = 0; i < 53; i++) if (cap[at + i] !== base + 8'(i)) miss++;
    chk(miss == 0 && mark_bad == 0, req, miss, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_clav == 1'b0 && cell_valid == 1'b0, "R1 reset outputs idle", {tx_clav, cell_valid}, 0);
    chk(par_err == 1'b0 && !err_soc_early && !err_soc_missing, "R8 reset flags clear", par_err, 0);
  endtask

  task automatic t_poll();
    logic v;
    poll(MY_ADDR, v);
    chk(v == 1'b1, "R1 clav on own address", v, 1);
    poll(OTHER, v);
    chk(v == 1'b0, "R1 clav low for other address", v, 0);
  endtask

  task automatic t_no_select();
    int c0 = cap_n;
    int m0 = n_miss;
    logic v;
    poll(MY_ADDR, v);
    cyc(OTHER, 1'b1, 1'b0, 16'h0, 1'b0);
    for (int w = 0; w < 53; w++) cyc(IDLE_A, 1'b0, (w == 0), {8'h0, 8'(w)}, odd_bit({8'h0, 8'(w)}, 1'b0));
    cyc(IDLE_A, 1'b1, 1'b0, 16'h0, 1'b0);
    // address shown only while enable is already low
    cyc(OTHER, 1'b0, 1'b0, 16'h0, 1'b1);
    cyc(MY_ADDR, 1'b0, 1'b0, 16'h0, 1'b1);
    for (int w = 0; w < 53; w++) cyc(IDLE_A, 1'b0, (w == 0), {8'h0, 8'(w)}, odd_bit({8'h0, 8'(w)}, 1'b0));
    cyc(IDLE_A, 1'b1, 1'b0, 16'h0, 1'b0);
    settle();
    chk(cap_n == c0, "R2 poll alone does not select", cap_n - c0, 0);
    chk(n_miss == m0, "R2 unselected words raise nothing", n_miss - m0, 0);
  endtask

  task automatic t_narrow();
    int c0 = cap_n;
    cfg_wide = 1'b0;
    send_cell(1'b0, 8'h10, -1, -1, -1, 1'b0, 1'b1);
    settle();
    chk(cap_n - c0 == 53, "R6 narrow cell length", cap_n - c0, 53);
    cell_matches(c0, 8'h10, "R6 narrow bytes, upper lane ignored");
    chk(par_err == 1'b0, "R6 parity over low byte only", par_err, 0);
    chk(mark_bad == 0, "R9 sof/eof markers", mark_bad, 0);
  endtask

  task automatic t_wide();
    int c0 = cap_n;
    cfg_wide = 1'b1;
    send_cell(1'b1, 8'h40, -1, -1, -1, 1'b0, 1'b0);
    settle();
    chk(cap_n - c0 == 53, "R7 wide cell length", cap_n - c0, 53);
    cell_matches(c0, 8'h40, "R7 filler removed");
    chk(par_err == 1'b0, "R7 parity over 16 bits", par_err, 0);
    cfg_wide = 1'b0;
  endtask

  task automatic t_pause();
    int c0 = cap_n;
    int m0 = n_miss;
    send_cell(1'b0, 8'h70, -1, -1, 20, 1'b0, 1'b0);
    settle();
    cell_matches(c0, 8'h70, "R3 narrow pause and reselect");
    c0 = cap_n;
    cfg_wide = 1'b1;
    send_cell(1'b1, 8'hA0, -1, -1, 10, 1'b1, 1'b0);
    settle();
    chk(cap_n - c0 == 53, "R3 stray word not taken", cap_n - c0, 53);
    cell_matches(c0, 8'hA0, "R3 wide pause with stray word");
    chk(n_miss == m0, "R3 stray word raises nothing", n_miss - m0, 0);
    cfg_wide = 1'b0;
  endtask

  task automatic t_early();
    int c0 = cap_n;
    int e0 = n_early;
    send_cell(1'b0, 8'h20, 10, -1, -1, 1'b0, 1'b0);
    send_cell(1'b0, 8'h90, -1, -1, -1, 1'b0, 1'b0);
    settle();
    chk(n_early - e0 == 1, "R4 early soc pulse", n_early - e0, 1);
    chk(cap_n - c0 == 53, "R4 partial cell discarded", cap_n - c0, 53);
    cell_matches(c0, 8'h90, "R4 new cell started by early soc");
  endtask

  task automatic t_missing();
    int c0 = cap_n;
    int m0 = n_miss;
    cyc(MY_ADDR, 1'b1, 1'b0, 16'h0, 1'b0);
    cyc(IDLE_A, 1'b0, 1'b0, 16'h0033, odd_bit(16'h0033, 1'b0));
    cyc(IDLE_A, 1'b1, 1'b0, 16'h0, 1'b0);
    settle();
    chk(n_miss - m0 == 1, "R5 missing soc pulse", n_miss - m0, 1);
    chk(cap_n == c0, "R5 stray word dropped", cap_n - c0, 0);
  endtask

  task automatic t_parity();
    int c0 = cap_n;
    send_cell(1'b0, 8'h55, -1, 7, -1, 1'b0, 1'b0);
    settle();
    chk(par_err == 1'b1, "R8 parity error sticky", par_err, 1);
    cell_matches(c0, 8'h55, "R8 cell kept despite parity error");
    @(posedge clk); #1 clr_par_err = 1'b1;
    @(posedge clk); #1 clr_par_err = 1'b0;
    @(negedge clk);
    chk(par_err == 1'b0, "R8 clear drops flag", par_err, 0);
  endtask

  task automatic t_full();
    int c0 = cap_n;
    logic v;
    logic [7:0] held;
    cell_ready = 1'b0;
    send_cell(1'b0, 8'h01, -1, -1, -1, 1'b0, 1'b0);
    poll(MY_ADDR, v);
    chk(v == 1'b1, "R1 one slot still free", v, 1);
    send_cell(1'b0, 8'hB0, -1, -1, -1, 1'b0, 1'b0);
    poll(MY_ADDR, v);
    chk(v == 1'b0, "R1 clav low when full", v, 0);
    @(negedge clk);
    held = cell_byte;
    repeat (5) @(negedge clk);
    chk(cell_valid && cell_byte == held && cell_sof, "R9 output holds while stalled", cell_byte, held);
    send_cell(1'b0, 8'hC8, -1, -1, -1, 1'b0, 1'b0);
    @(posedge clk); #1 cell_ready = 1'b1;
    repeat (2) settle();
    chk(cap_n - c0 == 106, "R10 cell into full buffer dropped", cap_n - c0, 106);
    cell_matches(c0, 8'h01, "R9 first cell in order");
    cell_matches(c0 + 53, 8'hB0, "R9 second cell in order");
    poll(MY_ADDR, v);
    chk(v == 1'b1, "R1 clav back after drain", v, 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_poll();
    t_no_select();
    t_narrow();
    t_wide();
    t_pause();
    t_early();
    t_missing();
    t_parity();
    t_full();
    finish_run();
  end
endmodule